// File: doc/BRIEF.md
# E3 Nibble-Parallel Transmit Payload Interface

This block sits between a system-side payload source that works four bits at a time and a serial E3 transmit path running on the bit clock. From the bit clock it derives a nibble clock at one quarter of the bit rate. It captures each 4-bit payload nibble at a fixed point inside the nibble period. It then shifts the nibble out on a single-bit output, most significant bit first, and the output nibble boundaries line up with the rising edges of the nibble clock.

The frame is byte-oriented, 537 bytes long, and carries seven overhead bytes: two fixed alignment bytes at the start and five auxiliary bytes whose contents come from an input bus. The block puts the overhead nibbles into the stream by itself. One nibble period before each overhead slot it raises a hold-off indicator, so the source holds back its payload and no payload nibble is lost or overwritten. A frame-end output marks the last nibble slot of every frame, and the source starts the next frame's payload from that point.

Top module: `e3np_tx_if`

## Requirements
- R1: `nib_clk_o` has a period of 4 bit-clock cycles. It is high for 2 cycles and low for 2 cycles, and it rises on the first `clk` edge after reset is released.
- R2: `tx_nib_i` is captured only at the third rising `clk` edge after each rising edge of `nib_clk_o`. Values present on the port during the rest of the nibble period do not reach the output.
- R3: A nibble captured in one nibble period is sent in the next one. It goes out on `ser_o` MSB first, one bit per `clk` cycle, and its first bit appears on the `clk` edge that raises `nib_clk_o`.
- R4: A frame has 1074 nibble slots. `frame_end_o` is high for exactly one nibble period (4 cycles), during the period in which the last slot (1073) is sent. The first nibble period after reset is such a last-slot period.
- R5: `oh_ind_o` changes only when `nib_clk_o` rises. It is high during a nibble period exactly when the slot sent in the following period is an overhead slot. This gives 4 consecutive high periods before and across the two alignment bytes, and 2 for each auxiliary byte.
- R6: Slots 0 to 3 (bytes 0 and 1) carry the nibbles F, 6, 2, 8, which are the bytes 0xF6 then 0x28, high nibble first.
- R7: Auxiliary byte k (k = 0..4) occupies byte offset 59*(k+1) and is taken from `aux_oh_i[8k+7:8k]`, high nibble first. The value used is the one on `aux_oh_i` at the `clk` edge where `frame_end_o` rises. Later changes within the frame do not appear until the next frame.
- R8: Every payload slot carries the nibble captured during the previous nibble period. Nibbles driven during periods in which `oh_ind_o` is high never appear on `ser_o`, so payload comes out exactly once and in order.
- R9: While `rst` is high, `nib_clk_o`, `frame_end_o`, `oh_ind_o` and `ser_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_nib_i | input | 4 | Payload nibble from the system side |
| aux_oh_i | input | 40 | Five auxiliary overhead bytes, byte k at bits 8k+7:8k |
| nib_clk_o | output | 1 | Nibble clock, one quarter of the bit rate |
| frame_end_o | output | 1 | High during the period of the frame's last nibble slot |
| oh_ind_o | output | 1 | Hold-off request, high one period ahead of each overhead slot |
| ser_o | output | 1 | Serialized frame stream, MSB of each nibble first |

## Verification
In the steady pattern, the source holds its nibble for the whole period and drives a different, deliberately wrong nibble whenever the hold-off indicator is high. Under that pattern, a design that writes payload into overhead slots, drops a nibble or repeats one produces a stream that differs from the expected one. In the narrow-window pattern, valid data is present only in the bit cycle that ends at the third edge, and wrong data is present on either side of it. This separates correct capture timing from capture one edge early or late. The auxiliary bus is also changed part-way through each frame, before the first auxiliary slot, which shows whether the overhead values are sampled once per frame or read live.

// File: rtl/e3np_pkg.sv
package e3np_pkg;

  localparam int NIB_W    = 4;
  localparam int OH_BYTE_W = 8;

  localparam logic [OH_BYTE_W-1:0] ALIGN_BYTE_A = 8'hF6;
  localparam logic [OH_BYTE_W-1:0] ALIGN_BYTE_B = 8'h28;

  // Bit-clock phase inside one nibble period; PH_RISE follows the edge
  // that raises the nibble clock.
  typedef enum logic [1:0] {
    PH_RISE  = 2'd0,
    PH_HIGH  = 2'd1,
    PH_LATCH = 2'd2,
    PH_LOAD  = 2'd3
  } nib_phase_e;

endpackage

// File: rtl/e3np_phase_gen.sv
module e3np_phase_gen
  import e3np_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output logic nib_clk_o,
  output logic latch_o,
  output logic load_o
);

  nib_phase_e ph_q;
  logic       nib_clk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_LOAD;
      nib_clk_q <= 1'b0;
    end else begin
      ph_q      <= nib_phase_e'(ph_q + 2'd1);
      nib_clk_q <= (ph_q == PH_LOAD) || (ph_q == PH_RISE);
    end
  end

  assign nib_clk_o = nib_clk_q;
  // Edge leaving PH_LATCH is the third edge after the nibble-clock rise.
  assign latch_o   = (ph_q == PH_LATCH);
  assign load_o    = (ph_q == PH_LOAD);

endmodule

// File: rtl/e3np_slot_ctr.sv
module e3np_slot_ctr
  import e3np_pkg::*;
#(
  parameter int FRAME_BYTES = 537,
  parameter int ROW_BYTES   = 59,
  parameter int NUM_AUX     = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           adv_i,
  input  logic [NUM_AUX*OH_BYTE_W-1:0]   aux_i,
  output logic                           nxt_is_oh_o,
  output logic [NIB_W-1:0]               nxt_oh_nib_o,
  output logic                           frame_end_o,
  output logic                           oh_ind_o
);

  localparam int NIBS = 2 * FRAME_BYTES;
  localparam int LAST = NIBS - 1;
  localparam int SW   = $clog2(NIBS);
  localparam int BW   = SW - 1;

  typedef logic [SW-1:0] slot_t;

  slot_t                         slot_q, nxt, nxt2;
  logic [BW-1:0]                 nxt_b, nxt2_b;
  logic [NUM_AUX-1:0]            hit_n, hit_n2;
  logic [NUM_AUX*OH_BYTE_W-1:0]  aux_q;
  logic                          fe_q, ohi_q;
  logic                          oh_n2;
  logic [OH_BYTE_W-1:0]          oh_byte;

  assign nxt    = (slot_q == slot_t'(LAST)) ? '0 : slot_q + 1'b1;
  assign nxt2   = (nxt == slot_t'(LAST)) ? '0 : nxt + 1'b1;
  assign nxt_b  = nxt[SW-1:1];
  assign nxt2_b = nxt2[SW-1:1];

  for (genvar k = 0; k < NUM_AUX; k++) begin : g_aux_hit
    localparam int POS = ROW_BYTES * (k + 1);
    assign hit_n[k]  = (nxt_b  == BW'(POS));
    assign hit_n2[k] = (nxt2_b == BW'(POS));
  end

  assign nxt_is_oh_o = (nxt_b  < BW'(2)) || (|hit_n);
  assign oh_n2       = (nxt2_b < BW'(2)) || (|hit_n2);

  always_comb begin
    oh_byte = '0;
    if (nxt_b == BW'(0)) begin
      oh_byte = ALIGN_BYTE_A;
    end else if (nxt_b == BW'(1)) begin
      oh_byte = ALIGN_BYTE_B;
    end
    for (int k = 0; k < NUM_AUX; k++) begin
      if (hit_n[k]) begin
        oh_byte = aux_q[k*OH_BYTE_W +: OH_BYTE_W];
      end
    end
  end

  assign nxt_oh_nib_o = nxt[0] ? oh_byte[NIB_W-1:0] : oh_byte[OH_BYTE_W-1:NIB_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= slot_t'(LAST - 1);
      fe_q   <= 1'b0;
      ohi_q  <= 1'b0;
      aux_q  <= '0;
    end else if (adv_i) begin
      slot_q <= nxt;
      fe_q   <= (nxt == slot_t'(LAST));
      ohi_q  <= oh_n2;
      if (nxt == slot_t'(LAST)) begin
        aux_q <= aux_i;
      end
    end
  end

  assign frame_end_o = fe_q;
  assign oh_ind_o    = ohi_q;

endmodule

// File: rtl/e3np_serializer.sv
module e3np_serializer
  import e3np_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             latch_i,
  input  logic             load_i,
  input  logic             use_oh_i,
  input  logic [NIB_W-1:0] oh_nib_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             ser_o
);

  logic [NIB_W-1:0] hold_q;
  logic [NIB_W-1:0] word;
  logic [NIB_W-2:0] sh_q;
  logic             ser_q;

  assign word = use_oh_i ? oh_nib_i : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      sh_q   <= '0;
      ser_q  <= 1'b0;
    end else begin
      if (latch_i) begin
        hold_q <= nib_i;
      end
      if (load_i) begin
        ser_q <= word[NIB_W-1];
        sh_q  <= word[NIB_W-2:0];
      end else begin
        ser_q <= sh_q[NIB_W-2];
        sh_q  <= {sh_q[NIB_W-3:0], 1'b0};
      end
    end
  end

  assign ser_o = ser_q;

endmodule

// File: rtl/e3np_tx_if.sv
module e3np_tx_if
  import e3np_pkg::*;
#(
  parameter int FRAME_BYTES = 537,
  parameter int ROW_BYTES   = 59,
  parameter int NUM_AUX     = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NIB_W-1:0]             tx_nib_i,
  input  logic [NUM_AUX*OH_BYTE_W-1:0] aux_oh_i,
  output logic                         nib_clk_o,
  output logic                         frame_end_o,
  output logic                         oh_ind_o,
  output logic                         ser_o
);

  logic             latch, load;
  logic             nxt_is_oh;
  logic [NIB_W-1:0] nxt_oh_nib;

  e3np_phase_gen u_phase (
    .clk       (clk),
    .rst       (rst),
    .nib_clk_o (nib_clk_o),
    .latch_o   (latch),
    .load_o    (load)
  );

  e3np_slot_ctr #(
    .FRAME_BYTES (FRAME_BYTES),
    .ROW_BYTES   (ROW_BYTES),
    .NUM_AUX     (NUM_AUX)
  ) u_slot (
    .clk          (clk),
    .rst          (rst),
    .adv_i        (load),
    .aux_i        (aux_oh_i),
    .nxt_is_oh_o  (nxt_is_oh),
    .nxt_oh_nib_o (nxt_oh_nib),
    .frame_end_o  (frame_end_o),
    .oh_ind_o     (oh_ind_o)
  );

  e3np_serializer u_ser (
    .clk      (clk),
    .rst      (rst),
    .latch_i  (latch),
    .load_i   (load),
    .use_oh_i (nxt_is_oh),
    .oh_nib_i (nxt_oh_nib),
    .nib_i    (tx_nib_i),
    .ser_o    (ser_o)
  );

endmodule

// File: rtl/e3np_tx_if_chk.sv
module e3np_tx_if_chk (
  input logic clk,
  input logic rst,
  input logic nib_clk,
  input logic frame_end,
  input logic oh_ind
);

  p_nibclk_shape_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(nib_clk) |=> nib_clk ##1 !nib_clk ##1 !nib_clk ##1 nib_clk);

  p_fe_width_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_end) |=> frame_end ##1 frame_end ##1 frame_end ##1 !frame_end);

  p_fe_align_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_end) |-> $rose(nib_clk));

  p_ohind_align_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(oh_ind) |-> $rose(nib_clk));

  p_ohind_at_fe_r5: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> oh_ind);

endmodule

bind e3np_tx_if e3np_tx_if_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .nib_clk   (nib_clk_o),
  .frame_end (frame_end_o),
  .oh_ind    (oh_ind_o)
);

// File: tb/e3np_tx_if_tb_top.sv
`timescale 1ns/1ps
module e3np_tx_if_tb_top;

  localparam int FB   = 537;
  localparam int ROW  = 59;
  localparam int NA   = 5;
  localparam int NIBS = FB * 2;
  localparam int LAST = NIBS - 1;
  localparam int NFR  = 4;
  localparam int TIGHT_FRAME = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [3:0]      tx_nib = 4'h0;
  logic [NA*8-1:0] aux = 40'hC3_A5_5A_3C_96;
  logic            nib_clk, frame_end, oh_ind, ser;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0] exp_q[$];

  always #2.5 clk = ~clk;

  e3np_tx_if dut_i (
    .clk         (clk),
    .rst         (rst),
    .tx_nib_i    (tx_nib),
    .aux_oh_i    (aux),
    .nib_clk_o   (nib_clk),
    .frame_end_o (frame_end),
    .oh_ind_o    (oh_ind),
    .ser_o       (ser)
  );

  function automatic int nxt_slot(int s);
    return (s == LAST) ? 0 : s + 1;
  endfunction

  function automatic bit is_oh(int s);
    int b = s / 2;
    if (b < 2) return 1'b1;
    for (int k = 0; k < NA; k++) if (b == ROW * (k + 1)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [3:0] oh_exp(int s, logic [NA*8-1:0] a);
    logic [7:0] v = 8'h00;
    int b = s / 2;
    if (b == 0) v = 8'hF6;
    else if (b == 1) v = 8'h28;
    for (int k = 0; k < NA; k++) if (b == ROW * (k + 1)) v = a[8*k +: 8];
    return (s % 2 == 1) ? v[3:0] : v[7:4];
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp, input int slot);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s slot=%0d actual=%0h expected=%0h", tag, slot, act, exp);
    end
  endtask

  // Source model: obeys the hold-off rule, pushes every nibble it sends.
  task automatic driver();
    int slot = LAST - 1;
    int frame = -1;
    int pcnt = 0;
    logic [3:0] pv;
    bit hold;
    while (frame < NFR) begin
      @(posedge nib_clk);
      @(negedge clk);
      slot = nxt_slot(slot);
      if (slot == 0) frame++;
      if (slot == 100) aux = {aux[31:0], aux[39:32]} ^ 40'h5A_3C_96_12_E7;  // R7 mid-frame change
      hold = oh_ind;
      pv = 4'((pcnt * 5 + 3) % 16);
      if (!hold) begin
        exp_q.push_back(pv);
        pcnt++;
      end
      if (frame == TIGHT_FRAME) begin
        // R2: valid only in the cycle ending at the third edge
        tx_nib = ~pv;
        @(negedge clk);
        @(negedge clk);
        tx_nib = hold ? ~pv : pv;
        @(negedge clk);
        tx_nib = ~pv;
      end else begin
        tx_nib = hold ? ~pv : pv;  // R8: garbage while held off
      end
    end
  endtask

  task automatic monitor();
    int slot = LAST - 1;
    int frame = -1;
    logic [NA*8-1:0] snap = '0;
    logic [3:0] got, pat, exp;
    logic fe, oi;
    string tag;
    while (frame < NFR) begin
      @(posedge nib_clk);
      slot = nxt_slot(slot);
      if (slot == 0) frame++;
      fe = 1'b0; oi = 1'b0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        got[3-i] = ser;
        pat[3-i] = nib_clk;
        if (i == 0) begin
          fe = frame_end;
          oi = oh_ind;
        end
      end
      if (slot == LAST) snap = aux;
      chk("R1 nib_clk shape", pat, 4'b1100, slot);
      chk("R4 frame_end", {3'b0, fe}, {3'b0, (slot == LAST)}, slot);
      chk("R5 oh_ind", {3'b0, oi}, {3'b0, is_oh(nxt_slot(slot))}, slot);
      if (frame >= 0) begin
        if (is_oh(slot)) begin
          exp = oh_exp(slot, snap);
          tag = (slot < 4) ? "R6 R3 align nibble" : "R7 R3 aux nibble";
          chk(tag, got, exp, slot);
        end else if (exp_q.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R8 slot=%0d actual=%0h expected=queued payload", slot, got);
        end else begin
          exp = exp_q.pop_front();
          tag = (frame == TIGHT_FRAME) ? "R2 R3 payload" : "R8 R3 payload";
          chk(tag, got, exp, slot);
        end
      end
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R9 reset nib_clk", {3'b0, nib_clk}, 4'h0, -1);
    chk("R9 reset frame_end", {3'b0, frame_end}, 4'h0, -1);
    chk("R9 reset oh_ind", {3'b0, oh_ind}, 4'h0, -1);
    chk("R9 reset ser", {3'b0, ser}, 4'h0, -1);
    rst = 1'b0;
    fork
      driver();
      monitor();
    join
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule